// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one indivisible memory update on behalf of a decoded atomic store instruction. It takes a request made of an access size (32-bit or 64-bit), the low bits of a base register, a signed 16-bit displacement, an operation code, a fetch flag, a source operand and the current value of register zero. It then runs a fixed sequence on a single-port synchronous memory with 64-bit words: it reads the addressed word, computes the new value, writes it back and reports a response. The memory lock output stays high across the whole access so that no other master can get in between the read and the write.

The supported updates are add, bitwise or, bitwise and, bitwise xor, exchange and compare-and-exchange. The compare-and-exchange comparand is register zero. The response names a register to update, either the source register or register zero, and carries the value that memory held before the update, zero-extended to 64 bits. A compare-and-exchange that finds a mismatch does not write memory, but it still responds. Only one request is in flight at a time, and a new request is accepted only while the block is idle.

Top module: `amo_rmw_unit`

## Requirements
- R1: The byte address is `req_base + sign_extend(req_offset)` modulo 2^ADDR_W. `mem_addr` carries that address shifted right by 3. A 64-bit access drives `mem_be` = 0xFF. A 32-bit access uses byte address bit 2 to pick the lane: 0x0F (bits 31:0) when the bit is 0, 0xF0 (bits 63:32) when it is 1.
- R2: Operation codes: 0 add, 1 or, 2 and, 3 xor. For these, the new memory value is the old value combined with the source operand. A 32-bit access wraps within its 32-bit lane and leaves the other lane of the word unchanged.
- R3: For codes 0 to 3 with `req_fetch`=1, the response has `rsp_wb_en`=1, `rsp_to_r0`=0 and `rsp_data` = the old memory value, zero-extended. With `req_fetch`=0, `rsp_wb_en`=0.
- R4: Code 4 (exchange) writes the source operand to memory. It always returns the old value to the source register (`rsp_wb_en`=1, `rsp_to_r0`=0), whatever `req_fetch` holds.
- R5: Code 5 (compare-and-exchange) writes the source operand only when the old value equals register zero. A 32-bit access compares the low 32 bits only. The response always has `rsp_wb_en`=1, `rsp_to_r0`=1 and the old value, zero-extended, whatever `req_fetch` holds.
- R6: A compare-and-exchange mismatch drives no write cycle at all and leaves memory unchanged, but the response still arrives.
- R7: Each request makes exactly one read cycle and at most one write cycle. `mem_lock` is high during both of these cycles and the cycles between them. `req_ready` is low while `mem_lock` is high. `rsp_valid` is a single-cycle pulse.
- R8: Codes 6 and 7 are reserved. They produce a response with `rsp_wb_en`=0 and no write cycle.
- R9: After reset, `req_ready`=1 and `mem_lock`, `mem_rd_en`, `mem_wr_en` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_op | input | 3 | Operation code (see R2, R4, R5, R8) |
| req_fetch | input | 1 | Return old value for codes 0-3 |
| req_base | input | ADDR_W | Low bits of the base register |
| req_offset | input | OFF_W | Signed displacement |
| req_src | input | 64 | Source operand |
| req_r0 | input | 64 | Comparand (register zero) |
| mem_lock | output | 1 | Memory held for this access |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W-3 | Word index |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after the strobe |
| rsp_valid | output | 1 | Response pulse |
| rsp_wb_en | output | 1 | Register write-back requested |
| rsp_to_r0 | output | 1 | 1 = write register zero, 0 = write source register |
| rsp_data | output | 64 | Old memory value, zero-extended |

## Verification
The bench targets 32-bit accesses in the upper lane where the addition carries out of bit 31. A design that lets that carry spill into the neighbouring lane, or that writes all eight bytes, corrupts the other half of the word. Compare-and-exchange is run with a register zero whose upper half differs while the lower half matches; a design that compares 64 bits there misses a write it owes. A mismatch is checked for any write strobe, which a design that always writes would show. Negative displacements, fetch-clear exchanges and the reserved codes show up sign-extension mistakes and forced-fetch mistakes as a wrong word index or a spurious write-back.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN = 64;
  localparam int HALF = 32;
  localparam int BE_W = XLEN / 8;

  localparam logic [2:0] OP_ADD     = 3'd0;
  localparam logic [2:0] OP_OR      = 3'd1;
  localparam logic [2:0] OP_AND     = 3'd2;
  localparam logic [2:0] OP_XOR     = 3'd3;
  localparam logic [2:0] OP_XCHG    = 3'd4;
  localparam logic [2:0] OP_CMPXCHG = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE,
    ST_RESPOND
  } amo_state_e;
endpackage

// File: rtl/amo_addr_gen.sv
module amo_addr_gen
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 16,
  localparam int WIDX_W = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic              dword,
  output logic [WIDX_W-1:0] word_idx,
  output logic              lane,
  output logic [BE_W-1:0]   be
);
  logic [ADDR_W-1:0] byte_addr;

  // displacement is sign-extended before the add
  assign byte_addr = base + ADDR_W'($signed(offset));
  assign word_idx  = WIDX_W'(byte_addr >> 3);
  assign lane      = byte_addr[2];

  for (genvar b = 0; b < BE_W; b++) begin : g_be
    localparam logic UPPER = (b >= BE_W / 2);
    assign be[b] = dword | (lane == UPPER);
  end
endmodule

// File: rtl/amo_combine.sv
module amo_combine
  import amo_pkg::*;
(
  input  logic [2:0]      op,
  input  logic            dword,
  input  logic            lane,
  input  logic            fetch,
  input  logic [XLEN-1:0] rdata,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] r0,
  output logic [XLEN-1:0] old_val,
  output logic [XLEN-1:0] wdata,
  output logic            do_write,
  output logic            wb_en,
  output logic            wb_to_r0
);
  logic [XLEN-1:0] res;
  logic            known;
  logic            match;

  always_comb begin
    old_val = dword ? rdata
                    : {{HALF{1'b0}}, (lane ? rdata[XLEN-1:HALF] : rdata[HALF-1:0])};
    known = 1'b1;
    res   = '0;
    case (op)
      OP_ADD:     res = old_val + src;
      OP_OR:      res = old_val | src;
      OP_AND:     res = old_val & src;
      OP_XOR:     res = old_val ^ src;
      OP_XCHG:    res = src;
      OP_CMPXCHG: res = src;
      default:    known = 1'b0;
    endcase
    match = dword ? (old_val == r0) : (old_val[HALF-1:0] == r0[HALF-1:0]);
    // a 32-bit result goes to both lanes, the byte enables pick one
    wdata    = dword ? res : {2{res[HALF-1:0]}};
    do_write = known && ((op != OP_CMPXCHG) || match);
    wb_en    = known && (fetch || (op == OP_XCHG) || (op == OP_CMPXCHG));
    wb_to_r0 = (op == OP_CMPXCHG);
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic do_write,
  output logic ready,
  output logic rd_en,
  output logic wr_en,
  output logic lock,
  output logic in_modify,
  output logic rsp_valid
);
  amo_state_e state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (start) nxt = ST_READ;
      ST_READ:    nxt = ST_MODIFY;
      ST_MODIFY:  nxt = do_write ? ST_WRITE : ST_RESPOND;
      ST_WRITE:   nxt = ST_RESPOND;
      ST_RESPOND: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  // outputs are registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ready     <= 1'b1;
      rd_en     <= 1'b0;
      wr_en     <= 1'b0;
      lock      <= 1'b0;
      in_modify <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state     <= nxt;
      ready     <= (nxt == ST_IDLE);
      rd_en     <= (nxt == ST_READ);
      wr_en     <= (nxt == ST_WRITE);
      lock      <= (nxt == ST_READ) || (nxt == ST_MODIFY) || (nxt == ST_WRITE);
      in_modify <= (nxt == ST_MODIFY);
      rsp_valid <= (nxt == ST_RESPOND);
    end
  end
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 16,
  localparam int WIDX_W = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_dword,
  input  logic [2:0]        req_op,
  input  logic              req_fetch,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [XLEN-1:0]   req_src,
  input  logic [XLEN-1:0]   req_r0,
  output logic              mem_lock,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [WIDX_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_wb_en,
  output logic              rsp_to_r0,
  output logic [XLEN-1:0]   rsp_data
);
  logic              accept;
  logic              in_modify;
  logic [WIDX_W-1:0] ag_idx;
  logic              ag_lane;
  logic [BE_W-1:0]   ag_be;

  logic              dword_q, lane_q, fetch_q;
  logic [2:0]        op_q;
  logic [XLEN-1:0]   src_q, r0_q;

  logic [XLEN-1:0]   cmb_old, cmb_wdata;
  logic              cmb_do_write, cmb_wb_en, cmb_to_r0;

  assign accept = req_valid && req_ready;

  amo_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base     (req_base),
    .offset   (req_offset),
    .dword    (req_dword),
    .word_idx (ag_idx),
    .lane     (ag_lane),
    .be       (ag_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dword_q  <= 1'b0;
      lane_q   <= 1'b0;
      fetch_q  <= 1'b0;
      op_q     <= '0;
      src_q    <= '0;
      r0_q     <= '0;
      mem_addr <= '0;
      mem_be   <= '0;
    end else if (accept) begin
      dword_q  <= req_dword;
      lane_q   <= ag_lane;
      fetch_q  <= req_fetch;
      op_q     <= req_op;
      src_q    <= req_src;
      r0_q     <= req_r0;
      mem_addr <= ag_idx;
      mem_be   <= ag_be;
    end
  end

  amo_combine u_cmb (
    .op       (op_q),
    .dword    (dword_q),
    .lane     (lane_q),
    .fetch    (fetch_q),
    .rdata    (mem_rdata),
    .src      (src_q),
    .r0       (r0_q),
    .old_val  (cmb_old),
    .wdata    (cmb_wdata),
    .do_write (cmb_do_write),
    .wb_en    (cmb_wb_en),
    .wb_to_r0 (cmb_to_r0)
  );

  amo_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .do_write  (cmb_do_write),
    .ready     (req_ready),
    .rd_en     (mem_rd_en),
    .wr_en     (mem_wr_en),
    .lock      (mem_lock),
    .in_modify (in_modify),
    .rsp_valid (rsp_valid)
  );

  // results are captured in the modify cycle, read data valid then
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wdata <= '0;
      rsp_data  <= '0;
      rsp_wb_en <= 1'b0;
      rsp_to_r0 <= 1'b0;
    end else if (in_modify) begin
      mem_wdata <= cmb_wdata;
      rsp_data  <= cmb_old;
      rsp_wb_en <= cmb_wb_en;
      rsp_to_r0 <= cmb_to_r0;
    end
  end

  p_lock_covers_access_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || mem_wr_en) |-> mem_lock);
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    mem_lock |-> !req_ready);
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  p_write_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_en) |-> $past(mem_rd_en, 2));
  p_mismatch_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (in_modify && !cmb_do_write) |=> !mem_wr_en);
  p_reserved_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (op_q <= OP_CMPXCHG));
  p_cmp_targets_r0_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && op_q == OP_CMPXCHG) |-> (rsp_wb_en && rsp_to_r0));
endmodule

// File: tb/amo_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module amo_rmw_unit_tb_top;
  localparam int ADDR_W = 16;
  localparam int WIDX_W = ADDR_W - 3;
  localparam int DEPTH  = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0, req_dword = 1'b0, req_fetch = 1'b0;
  logic [2:0]        req_op = '0;
  logic [ADDR_W-1:0] req_base = '0;
  logic [15:0]       req_offset = '0;
  logic [63:0]       req_src = '0, req_r0 = '0;
  logic              req_ready, mem_lock, mem_rd_en, mem_wr_en;
  logic [WIDX_W-1:0] mem_addr;
  logic [7:0]        mem_be;
  logic [63:0]       mem_wdata, mem_rdata, rsp_data;
  logic              rsp_valid, rsp_wb_en, rsp_to_r0;

  amo_rmw_unit #(.ADDR_W(ADDR_W), .OFF_W(16)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_dword(req_dword), .req_op(req_op), .req_fetch(req_fetch),
    .req_base(req_base), .req_offset(req_offset), .req_src(req_src), .req_r0(req_r0),
    .mem_lock(mem_lock), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_wb_en(rsp_wb_en), .rsp_to_r0(rsp_to_r0), .rsp_data(rsp_data)
  );

  // memory model and its shadow
  logic [63:0] ram  [DEPTH];
  logic [63:0] refm [DEPTH];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= ram[mem_addr[6:0]];
    if (mem_wr_en)
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) ram[mem_addr[6:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
  end

  typedef struct {
    logic [63:0] data;
    logic        wb_en;
    logic        to_r0;
    logic        wr;
    logic [6:0]  widx;
    logic [7:0]  be;
    logic [63:0] after;
    string       tag;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0, n_bad = 0, wr_seen = 0, rd_seen = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_amo(input logic dw, input logic [15:0] base, input logic [15:0] off,
                        input logic [2:0] op, input logic fetch, input logic [63:0] src,
                        input logic [63:0] r0, input string tag);
    exp_t e;
    logic [15:0] a;
    logic [63:0] old, res, nw;
    logic lane, known, match;
    a    = base + off;
    lane = a[2];
    e.widx = a[9:3];
    old = dw ? refm[e.widx] : {32'h0, (lane ? refm[e.widx][63:32] : refm[e.widx][31:0])};
    known = 1'b1;
    res = '0;
    case (op)
      3'd0: res = old + src;
      3'd1: res = old | src;
      3'd2: res = old & src;
      3'd3: res = old ^ src;
      3'd4, 3'd5: res = src;
      default: known = 1'b0;
    endcase
    match = dw ? (old == r0) : (old[31:0] == r0[31:0]);
    e.wr    = known && (op != 3'd5 || match);
    e.wb_en = known && (fetch || op >= 3'd4);
    e.to_r0 = (op == 3'd5);
    e.data  = old;
    e.be    = dw ? 8'hFF : (lane ? 8'hF0 : 8'h0F);
    nw = refm[e.widx];
    if (e.wr) begin
      if (dw) nw = res;
      else if (lane) nw[63:32] = res[31:0];
      else nw[31:0] = res[31:0];
    end
    refm[e.widx] = nw;
    e.after = nw;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_dword = dw; req_base = base; req_offset = off;
    req_op = op; req_fetch = fetch; req_src = src; req_r0 = r0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_lock && req_ready) chk(0, "R7 ready while locked", 64'(req_ready), 0);
      if ((mem_rd_en || mem_wr_en) && !mem_lock) chk(0, "R7 access without lock", 64'(mem_lock), 1);
      if (mem_rd_en) rd_seen++;
      if (mem_wr_en) begin
        wr_seen++;
        if (q.size() != 0) begin
          chk(mem_addr == WIDX_W'(q[0].widx), {"R1 word index ", q[0].tag}, 64'(mem_addr), 64'(q[0].widx));
          chk(mem_be == q[0].be, {"R1 byte enables ", q[0].tag}, 64'(mem_be), 64'(q[0].be));
        end
      end
      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "R7 response with nothing pending", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_wb_en == e.wb_en, {"R3/R4/R5/R8 wb_en ", e.tag}, 64'(rsp_wb_en), 64'(e.wb_en));
          if (e.wb_en) begin
            chk(rsp_data == e.data, {"R3/R4/R5 old value ", e.tag}, rsp_data, e.data);
            chk(rsp_to_r0 == e.to_r0, {"R4/R5 target ", e.tag}, 64'(rsp_to_r0), 64'(e.to_r0));
          end
          chk(wr_seen == int'(e.wr), {"R6/R8 write count ", e.tag}, 64'(wr_seen), 64'(e.wr));
          chk(rd_seen == 1, {"R7 read count ", e.tag}, 64'(rd_seen), 1);
          chk(ram[e.widx] == e.after, {"R2/R4/R5 memory word ", e.tag}, ram[e.widx], e.after);
        end
        wr_seen = 0;
        rd_seen = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i]  = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0001_0003_0005_0007);
      refm[i] = ram[i];
    end
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 1);
    chk(mem_lock == 1'b0, "R9 lock after reset", 64'(mem_lock), 0);
    chk(!mem_rd_en && !mem_wr_en, "R9 strobes after reset", 64'({mem_rd_en, mem_wr_en}), 0);
    chk(rsp_valid == 1'b0, "R9 rsp after reset", 64'(rsp_valid), 0);

    // R1 negative displacement, R2/R3 add with fetch
    do_amo(1, 16'h0100, 16'hFFF8, 3'd0, 1, 64'd5, 0, "add64 negoff");
    // R4 exchange with fetch clear still returns old value
    do_amo(1, 16'h0040, 16'h0000, 3'd4, 0, 64'hFFFF_FFFF_0000_0010, 0, "xchg64");
    // R2 upper lane wraps without touching the lower lane, R3 no fetch
    do_amo(0, 16'h0044, 16'h0000, 3'd0, 0, 64'd1, 0, "add32 wrap");
    do_amo(0, 16'h0040, 16'h0000, 3'd1, 1, 64'h0F00, 0, "or32 lane0");
    do_amo(1, 16'h0048, 16'h0000, 3'd2, 0, 64'hFF00_FF00_F0F0_0F0F, 0, "and64");
    do_amo(0, 16'h0010, 16'h000C, 3'd3, 1, 64'hFFFF_0000_1234_5678, 0, "xor32 lane1");
    // R5 match, R6 mismatch
    do_amo(1, 16'h0200, 16'h0010, 3'd5, 0, 64'hAAAA_5555_AAAA_5555, refm[7'h42], "cas64 hit");
    do_amo(1, 16'h0200, 16'h0010, 3'd5, 1, 64'h1, refm[7'h42] ^ 64'h1, "cas64 miss");
    do_amo(0, 16'h0208, 16'h0000, 3'd5, 0, 64'hCAFE_F00D_1357_9BDF,
           {32'hDEAD_BEEF, refm[7'h41][31:0]}, "cas32 hit upper differs");
    do_amo(0, 16'h020C, 16'h0000, 3'd5, 0, 64'h7, {refm[7'h41][63:32], 32'h0}, "cas32 miss lane1");
    // R8 reserved codes
    do_amo(1, 16'h0080, 16'h0000, 3'd6, 1, 64'h55, 0, "reserved6");
    do_amo(0, 16'h0084, 16'h0000, 3'd7, 1, 64'h55, 0, "reserved7");
    // R1 positive displacement wraps the byte address space
    do_amo(1, 16'hFFF8, 16'h0010, 3'd0, 1, 64'd3, 0, "add64 addr wrap");
    // mixed sweep across codes, sizes and lanes
    for (int i = 0; i < 30; i++)
      do_amo(logic'(i % 2), 16'(i * 12), 16'(i * 4), 3'(i % 8), logic'((i / 3) % 2),
             64'h9E37_79B9_7F4A_7C15 * 64'(i + 1), (i % 3 == 0) ? refm[7'(((i * 12) + (i * 4)) >> 3)] : 64'h0,
             "sweep");
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule